// File: doc/BRIEF.md
# Priority Interrupt Controller with Trigger Modes

This block gathers up to 64 synchronous request lines and turns them into one interrupt line for a processor. Every line has its own trigger setting (low level, high level, falling edge or rising edge) and a 3-bit priority. Edge-triggered lines hold a sticky latch that software clears with a packed command word. Level-triggered lines follow the live input.

A threshold register screens out sources whose priority does not exceed it. Among the sources that remain, an arbiter picks the one with the highest priority, and ties go to the lowest source number. The winner is registered into a status word, and the interrupt output is registered in the same cycle. A global enable bit gates delivery. Source number 0 is reserved and can never be configured or reported.

Software reaches the block over a plain synchronous register bus with address, write data, a write strobe and combinational read data. Register map:

| Address | Content |
|---------|---------|
| 0x00 | enable, bit 0 |
| 0x01 | threshold, bits 2:0 |
| 0x02 | status, read only |
| 0x04 | edge clear, sources 0..31 |
| 0x05 | edge clear, sources 32..63 |
| 0x40+n | priority of source n |
| 0x80+n | trigger mode of source n |

Top module: `pic_prio_ctrl`

## Requirements
- R1: While reset is asserted, and right after it, the status word reads 0x0001_0000, the interrupt output is 0, and every priority, mode, enable and threshold register reads 0.
- R2: Mode 00 makes a source pending while its input is low. Mode 01 makes it pending while its input is high. In both level modes pending follows the input with no latching.
- R3: Mode 10 latches a high-to-low transition and mode 11 latches a low-to-high transition. The latch stays set after the input returns, until it is cleared. Only mode bit 1 selects edge behaviour.
- R4: Address 0x04 clears latches of sources 0..31 and address 0x05 clears latches of sources 32..63. Within the addressed 32-source group, data bit 8 enables a clear of the source whose offset in the group is given by bits 3:0. Bit 24 with bits 19:16 does the same for offsets 16..31. A write without the enable bit clears nothing.
- R5: A priority register keeps only bits 2:0, and its other bits read 0. A source whose priority is 0 is never delivered, even while it is pending.
- R6: A source is eligible only when it is pending and its priority is strictly greater than the threshold at address 0x01.
- R7: Among eligible sources the highest priority wins. On equal priority the lower source number wins.
- R8: While enable bit 0 at address 0x00 is clear, the interrupt output is 0 and the status word reads 0x0001_0000.
- R9: Source 0 is reserved. Writes to its priority and mode registers are ignored, both read back 0, and it is never reported.
- R10: The status word (bit 16 = nothing pending, bits 5:0 = winning source) and the interrupt output are registered. They change one clock edge after a level input change and two edges after an edge input change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 64 | Synchronous request lines, one per source |
| addr_i | input | 8 | Register address |
| wdata_i | input | 32 | Write data |
| we_i | input | 1 | Write strobe, one cycle per write |
| rdata_o | output | 32 | Read data for addr_i |
| irq_o | output | 1 | Registered interrupt to the processor |

## Verification
The bench goes after these corner cases, each paired with the fault a wrong design would show:
- Priority ties: a controller that took the higher source number would report 5 where 3 is expected.
- Threshold equal to a source's priority: a non-strict compare would still deliver that source.
- Edge latches after the input returns: a design that lost them would drop the status to "nothing pending" too early.
- Clear commands: a clear without its enable bit, a clear aimed at the wrong group, and a clear in the upper half of a group. Ignoring the enable flag or the 16-bit shift would release the wrong latch or keep the right one.
- Source 0 writes, oversize priority values and a priority-0 source with a live request: these expose missing reserved-source handling and missing masking.
- Timing: the output is sampled before and after each register stage. An unregistered output, or a missing edge-detect stage, shows up one cycle early.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned ADDR_W     = 8;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned PG_W       = ADDR_W - 2;
  localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
  localparam logic [ADDR_W-1:0] A_THRESH   = 8'h01;
  localparam logic [ADDR_W-1:0] A_STATUS   = 8'h02;
  localparam logic [ADDR_W-1:0] A_CLR_BASE = 8'h04;
  localparam logic [1:0] PAGE_PRIO   = 2'b01;
  localparam logic [1:0] PAGE_MODE   = 2'b10;
  localparam int unsigned NONE_BIT   = 16;
  localparam int unsigned CLR_EN_BIT = 8;

  typedef enum logic [1:0] {
    TRG_LOW  = 2'b00,
    TRG_HIGH = 2'b01,
    TRG_FALL = 2'b10,
    TRG_RISE = 2'b11
  } trig_e;
endpackage

// File: rtl/pic_src_cell.sv
module pic_src_cell
  import pic_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic [1:0] mode_i,
  input  logic       clr_i,
  output logic       pend_o
);
  logic req_q;
  logic latch_q;
  logic latch_d;
  logic hit;

  // next state: trigger decode and sticky latch
  always_comb begin
    hit    = 1'b0;
    pend_o = 1'b0;
    unique case (trig_e'(mode_i))
      TRG_LOW:  pend_o = ~req_i;
      TRG_HIGH: pend_o = req_i;
      TRG_FALL: begin hit = req_q & ~req_i; pend_o = latch_q; end
      TRG_RISE: begin hit = ~req_q & req_i; pend_o = latch_q; end
      default:  ;
    endcase
    // a new event in the clear cycle wins over the clear
    latch_d = mode_i[1] & (hit | (latch_q & ~clr_i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      latch_q <= 1'b0;
    end else begin
      req_q   <= req_i;
      latch_q <= latch_d;
    end
  end

  AST_LEVEL_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mode_i[1]) |-> !latch_q); // R2
  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_q && mode_i[1] && !clr_i) |=> latch_q); // R3
endmodule

// File: rtl/pic_arbiter.sv
module pic_arbiter #(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 3,
  localparam int unsigned IDW = $clog2(NSRC)
) (
  input  logic [NSRC-1:0] pend_i,
  input  logic [PW-1:0]   prio_i [NSRC],
  input  logic [PW-1:0]   thr_i,
  output logic            any_o,
  output logic [IDW-1:0]  win_o
);
  logic [PW-1:0] best;

  // ascending scan; strict compare keeps the lowest index on ties
  always_comb begin
    best  = thr_i;
    any_o = 1'b0;
    win_o = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (pend_i[i] && (prio_i[i] > best)) begin
        best  = prio_i[i];
        win_o = IDW'(i);
        any_o = 1'b1;
      end
    end
  end

  always_comb begin
    if (any_o) begin
      AST_WIN_ELIGIBLE: assert (pend_i[win_o] && (prio_i[win_o] > thr_i)); // R6
    end
  end
endmodule

// File: rtl/pic_prio_ctrl.sv
module pic_prio_ctrl
  import pic_pkg::*;
#(
  parameter int unsigned NSRC = 64,
  parameter int unsigned PW   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              we_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  localparam int unsigned IDW = $clog2(NSRC);

  logic           en_q, en_d, en_we;
  logic [PW-1:0]  thr_q, thr_d;
  logic           thr_we;
  logic [PW-1:0]  prio_q [NSRC];
  logic [1:0]     mode_q [NSRC];
  logic [NSRC-1:0] pend;
  logic [NSRC-1:0] clr;
  logic           any;
  logic [IDW-1:0] win;
  logic           irq_q, irq_d;
  logic           none_q, none_d;
  logic [IDW-1:0] id_q, id_d;
  logic [IDW-1:0] rd_idx;
  logic           unused_wdata;

  assign unused_wdata = ^{wdata_i[31:25], wdata_i[23:20], wdata_i[15:9], wdata_i[7:4]};

  // global controls: next state
  assign en_we  = we_i && (addr_i == A_CTRL);
  assign en_d   = wdata_i[0];
  assign thr_we = we_i && (addr_i == A_THRESH);
  assign thr_d  = wdata_i[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else if (en_we) begin
      en_q <= en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_q <= '0;
    end else if (thr_we) begin
      thr_q <= thr_d;
    end
  end

  // per-source configuration, clear decode and trigger cell
  for (genvar i = 0; i < NSRC; i++) begin : g_src
    localparam int unsigned GRP  = i / 32;
    localparam int unsigned OFS  = ((i / 16) % 2) * 16;
    localparam int unsigned SUB  = i % 16;
    localparam logic [ADDR_W-1:0] A_CLR  = A_CLR_BASE + ADDR_W'(GRP);
    localparam logic [ADDR_W-1:0] A_PRIO = {PAGE_PRIO, PG_W'(i)};
    localparam logic [ADDR_W-1:0] A_MODE = {PAGE_MODE, PG_W'(i)};

    assign clr[i] = we_i && (addr_i == A_CLR) && wdata_i[OFS+CLR_EN_BIT]
                    && (wdata_i[OFS+3:OFS] == 4'(SUB));

    if (i == 0) begin : g_rsvd
      assign prio_q[i] = '0;
      assign mode_q[i] = 2'b00;
    end else begin : g_cfg
      logic prio_we, mode_we;
      assign prio_we = we_i && (addr_i == A_PRIO);
      assign mode_we = we_i && (addr_i == A_MODE);

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prio_q[i] <= '0;
        end else if (prio_we) begin
          prio_q[i] <= wdata_i[PW-1:0];
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          mode_q[i] <= 2'b00;
        end else if (mode_we) begin
          mode_q[i] <= wdata_i[1:0];
        end
      end
    end

    pic_src_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_i  (req_i[i]),
      .mode_i (mode_q[i]),
      .clr_i  (clr[i]),
      .pend_o (pend[i])
    );
  end

  pic_arbiter #(.NSRC(NSRC), .PW(PW)) u_arb (
    .pend_i (pend),
    .prio_i (prio_q),
    .thr_i  (thr_q),
    .any_o  (any),
    .win_o  (win)
  );

  // delivery stage: next state
  always_comb begin
    irq_d  = en_q & any;
    none_d = ~irq_d;
    id_d   = irq_d ? win : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      none_q <= 1'b1;
      id_q   <= '0;
    end else begin
      irq_q  <= irq_d;
      none_q <= none_d;
      id_q   <= id_d;
    end
  end

  assign irq_o = irq_q;

  // read mux
  assign rd_idx = addr_i[IDW-1:0];

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1 -: 2] == PAGE_PRIO) begin
      rdata_o[PW-1:0] = prio_q[rd_idx];
    end else if (addr_i[ADDR_W-1 -: 2] == PAGE_MODE) begin
      rdata_o[1:0] = mode_q[rd_idx];
    end else begin
      case (addr_i)
        A_CTRL:   rdata_o[0] = en_q;
        A_THRESH: rdata_o[PW-1:0] = thr_q;
        A_STATUS: begin
          rdata_o[NONE_BIT] = none_q;
          rdata_o[IDW-1:0]  = id_q;
        end
        default:  ;
      endcase
    end
  end

  AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !irq_o); // R8
  AST_STATUS_NOT_RSVD: assert property (@(posedge clk) disable iff (!rst_n)
    !none_q |-> (id_q != '0)); // R9
endmodule

// File: tb/pic_prio_ctrl_tb.sv
`timescale 1ns/1ps
module pic_prio_ctrl_tb;
  localparam int NV = 64;
  localparam logic [1:0] KW = 2'd0, KQ = 2'd1, KC = 2'd2, KR = 2'd3;
  localparam logic [31:0] NONE = 32'h0001_0000;

  // {kind, addr, data/expected, requirement}
  localparam logic [45:0] VEC [NV] = '{
    {KW, 8'h00, 32'h1, 4'd8},        // R8 enable
    {KW, 8'h01, 32'h1, 4'd6},        // R6 threshold 1
    {KC, 8'h02, NONE, 4'd5},         // R5 low-level pending but prio 0
    {KW, 8'h85, 32'h1, 4'd2},        // R2 src5 high level
    {KW, 8'h45, 32'h3, 4'd2},
    {KQ, 8'h05, 32'h1, 4'd2},
    {KC, 8'h02, 32'h5, 4'd2},
    {KQ, 8'h05, 32'h0, 4'd2},
    {KC, 8'h02, NONE, 4'd2},         // R2 no latching
    {KW, 8'h94, 32'h3, 4'd3},        // R3 src20 rising
    {KW, 8'h54, 32'h4, 4'd3},
    {KQ, 8'h14, 32'h1, 4'd3},
    {KC, 8'h02, 32'h14, 4'd3},
    {KQ, 8'h14, 32'h0, 4'd3},
    {KC, 8'h02, 32'h14, 4'd3},       // R3 sticky
    {KW, 8'h04, 32'h0104_0000, 4'd4},// R4 upper half of group 0
    {KC, 8'h02, NONE, 4'd4},
    {KQ, 8'h28, 32'h1, 4'd3},        // R3 src40 falling
    {KW, 8'hA8, 32'h2, 4'd3},
    {KW, 8'h68, 32'h4, 4'd3},
    {KQ, 8'h28, 32'h0, 4'd3},
    {KC, 8'h02, 32'h28, 4'd3},
    {KW, 8'h05, 32'h8, 4'd4},        // R4 no enable bit
    {KC, 8'h02, 32'h28, 4'd4},
    {KW, 8'h05, 32'h108, 4'd4},      // R4 group 1 lower half
    {KC, 8'h02, NONE, 4'd4},
    {KQ, 8'h05, 32'h1, 4'd7},        // R7 tie
    {KW, 8'h83, 32'h1, 4'd7},
    {KW, 8'h43, 32'h3, 4'd7},
    {KQ, 8'h03, 32'h1, 4'd7},
    {KC, 8'h02, 32'h3, 4'd7},
    {KW, 8'hB2, 32'h1, 4'd7},
    {KW, 8'h72, 32'h6, 4'd7},
    {KQ, 8'h32, 32'h1, 4'd7},
    {KC, 8'h02, 32'h32, 4'd7},
    {KW, 8'h01, 32'h6, 4'd6},        // R6 equal to threshold
    {KC, 8'h02, NONE, 4'd6},
    {KW, 8'h01, 32'h5, 4'd6},
    {KC, 8'h02, 32'h32, 4'd6},
    {KW, 8'h01, 32'h1, 4'd6},
    {KQ, 8'h32, 32'h0, 4'd7},
    {KC, 8'h02, 32'h3, 4'd7},
    {KW, 8'h00, 32'h0, 4'd8},        // R8 disable
    {KC, 8'h02, NONE, 4'd8},
    {KW, 8'h00, 32'h1, 4'd8},
    {KC, 8'h02, 32'h3, 4'd8},
    {KW, 8'h40, 32'h7, 4'd9},        // R9 source 0
    {KW, 8'h80, 32'h1, 4'd9},
    {KQ, 8'h00, 32'h1, 4'd9},
    {KR, 8'h40, 32'h0, 4'd9},
    {KR, 8'h80, 32'h0, 4'd9},
    {KW, 8'h43, 32'hFF, 4'd5},       // R5 width of priority
    {KR, 8'h43, 32'h7, 4'd5},
    {KQ, 8'h03, 32'h0, 4'd4},
    {KC, 8'h02, 32'h5, 4'd4},
    {KW, 8'hB8, 32'h3, 4'd4},        // R4 src56 rising, prio 7
    {KW, 8'h78, 32'h7, 4'd4},
    {KQ, 8'h38, 32'h1, 4'd4},
    {KC, 8'h02, 32'h38, 4'd4},
    {KW, 8'h05, 32'h0108_0000, 4'd4},// R4 upper half of group 1
    {KC, 8'h02, 32'h5, 4'd4},
    {KW, 8'h45, 32'h0, 4'd5},        // R5 prio 0 blocks live request
    {KC, 8'h02, NONE, 4'd5},
    {KR, 8'h85, 32'h1, 4'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [63:0] req;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic        we;
  logic [31:0] rdata;
  logic        irq;
  int          checks = 0;
  int          fails  = 0;

  pic_prio_ctrl u_dut (
    .clk (clk), .rst_n (rst_n), .req_i (req), .addr_i (addr),
    .wdata_i (wdata), .we_i (we), .rdata_o (rdata), .irq_o (irq)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", rq, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    #1 we = 1'b0;
  endtask

  task automatic set_req(input int idx, input logic v);
    @(negedge clk);
    req[idx] = v;
    @(posedge clk);
  endtask

  task automatic rd_chk(input string rq, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    addr = a;
    #1 chk(rq, rdata, exp);
  endtask

  task automatic stat_chk(input string rq, input logic [31:0] exp);
    repeat (2) @(posedge clk);
    rd_chk(rq, 8'h02, exp);
    chk(rq, {31'b0, irq}, {31'b0, ~exp[16]});
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: got hung expected done");
    summary();
  end

  initial begin
    rst_n = 1'b0; req = '0; addr = '0; wdata = '0; we = 1'b0;
    // R1 reset state
    #1 chk("R1", {31'b0, irq}, 32'h0);
    rd_chk("R1", 8'h02, NONE);
    @(negedge clk) rst_n = 1'b1;
    rd_chk("R1", 8'h02, NONE);
    rd_chk("R1", 8'h45, 32'h0);
    rd_chk("R1", 8'h85, 32'h0);
    rd_chk("R1", 8'h00, 32'h0);
    rd_chk("R1", 8'h01, 32'h0);

    for (int v = 0; v < NV; v++) begin
      logic [45:0] e;
      string       tag;
      e   = VEC[v];
      tag = $sformatf("R%0d", e[3:0]);
      case (e[45:44])
        KW:      wr(e[43:36], e[35:4]);
        KQ:      set_req(int'(e[41:36]), e[4]);
        KC:      stat_chk(tag, e[35:4]);
        default: rd_chk(tag, e[43:36], e[35:4]);
      endcase
    end

    // R2 active-low level on source 9
    set_req(9, 1'b1);
    wr(8'h49, 32'h2);
    stat_chk("R2", NONE);
    set_req(9, 1'b0);
    stat_chk("R2", 32'h9);
    set_req(9, 1'b1);
    stat_chk("R2", NONE);

    // R10 level path: one register stage
    set_req(5, 1'b0);
    wr(8'h45, 32'h3);
    stat_chk("R10", NONE);
    @(negedge clk) req[5] = 1'b1;
    #1 chk("R10", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10", {31'b0, irq}, 32'h1);
    rd_chk("R10", 8'h02, 32'h5);
    set_req(5, 1'b0);
    stat_chk("R10", NONE);

    // R10 edge path: two register stages (src20 rising, prio 4)
    @(negedge clk) req[20] = 1'b1;
    @(negedge clk);
    chk("R10", {31'b0, irq}, 32'h0);
    @(negedge clk);
    chk("R10", {31'b0, irq}, 32'h1);
    rd_chk("R3", 8'h02, 32'h14);

    // R1 reset in mid-run
    @(negedge clk) rst_n = 1'b0;
    #1 chk("R1", {31'b0, irq}, 32'h0);
    rd_chk("R1", 8'h02, NONE);
    rd_chk("R1", 8'h54, 32'h0);
    rd_chk("R1", 8'h94, 32'h0);
    summary();
  end
endmodule